// File: doc/BRIEF.md
# LCD Common Row Scan Timing Generator

This block produces the row (common) scan timing for a multiplexed dot-matrix LCD. Every pulse of a line-clock strobe moves a line counter forward. The counter selects exactly one of sixteen common outputs, or none of them when the current line belongs to a partner chip. The counter also produces the frame-inversion signal FR, which flips once per frame.

Two scan lengths are available: 16 lines or 32 lines.
- In the 32-line mode, two identical instances share the scan. The master drives commons for lines 0 to 15 and generates FR. The slave drives commons for lines 16 to 31 and takes FR from the master.
- A slave realigns its own counter whenever it sees the master's FR change.

A start-line register rotates the display-memory row fetched for each scan line.

Top module: `lcd_com_timing`

## Requirements
- R1: After reset the line index is 0, the internal frame bit and start line are 0, the row address is 0, and in master 16-line mode com_sel is 16'h0001.
- R2: Each cycle with cl_step high moves line_idx forward by one. With cl_step low, line_idx holds.
- R3: With duty32=0 the line index counts from 0 to 15 and then returns to 0. With duty32=1 it counts from 0 to 31 and then returns to 0.
- R4: In master mode (is_slave=0), fr_out inverts on the same step that returns line_idx to 0, and holds on every other cycle.
- R5: In slave mode (is_slave=1), fr_out equals fr_in in the same cycle.
- R6: With duty32=0, com_sel has only bit line_idx[3:0] set, on every line.
- R7: With duty32=1, a master sets com_sel bit line_idx[3:0] for lines 0 to 15 and drives all zeros for lines 16 to 31. A slave does the reverse.
- R8: row_addr equals (start line + line_idx) modulo 32.
- R9: A cycle with start_load high stores start_d as the start line, and the new value is used from the next cycle onward. Otherwise the start line holds.
- R10: In slave mode, a step whose fr_in differs from the fr_in value captured at the previous step sets line_idx to 1, regardless of the count. This step does not count as a wrap.
- R11: If duty32 drops to 0 while line_idx is 15 or more, the next step returns line_idx to 0 and counts as a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_step | input | 1 | One-cycle strobe marking a line-clock edge |
| duty32 | input | 1 | 0: 16-line scan, 1: 32-line scan |
| is_slave | input | 1 | 0: master (generates FR), 1: slave (follows fr_in) |
| fr_in | input | 1 | Frame signal from the master, used in slave mode |
| start_load | input | 1 | Load strobe for the start-line register |
| start_d | input | 5 | New start line |
| fr_out | output | 1 | Frame-inversion signal |
| line_idx | output | 5 | Current scan line |
| row_addr | output | 5 | Display-memory row for the current line |
| com_sel | output | 16 | One-hot active common, all zero when deselected |

## Verification
The hardest state to reach from the ports is a slave whose counter disagrees with the master's frame boundary. The stimulus reaches it by running the instance as a master for a while, then switching it to slave mode with an FR pattern that the bench chooses. The bench then flips fr_in on a step in the middle of a frame, which forces a realignment away from the natural wrap. The duty drop is reached the same way: the bench drives the counter past line 15 in 32-line mode and then lowers duty32 before the next step.

// File: rtl/lct_pkg.sv
package lct_pkg;
  parameter int unsigned COM_N    = 16;
  parameter int unsigned LINE_MAX = 2 * COM_N;
  parameter int unsigned LW       = $clog2(LINE_MAX);
  parameter int unsigned CW       = $clog2(COM_N);

  typedef logic [LW-1:0] line_t;

  // Display-memory row for a scan line, modulo LINE_MAX (a power of two).
  function automatic line_t row_of(input line_t start, input line_t line);
    line_t r;
    r = start + line;
    return r;
  endfunction

  // Highest line index of the selected scan length.
  function automatic line_t last_line(input logic duty32);
    return duty32 ? line_t'(LINE_MAX - 1) : line_t'(COM_N - 1);
  endfunction

  // True when this chip's commons own the current line.
  function automatic logic bank_active(input logic duty32, input logic slave,
                                       input line_t line);
    if (!duty32) return 1'b1;
    return slave ? line[LW-1] : ~line[LW-1];
  endfunction
endpackage

// File: rtl/lct_line_ctr.sv
module lct_line_ctr
  import lct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cl_step,
  input  logic  duty32,
  input  logic  is_slave,
  input  logic  fr_in,
  output line_t line_q,
  output logic  fr_q,
  output logic  wrap_evt,
  output logic  resync_evt
);
  logic fr_seen;

  assign resync_evt = cl_step & is_slave & (fr_in ^ fr_seen);
  assign wrap_evt   = cl_step & ~resync_evt & (line_q >= last_line(duty32));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      fr_q    <= 1'b0;
      fr_seen <= 1'b0;
    end else begin
      if (resync_evt)    line_q <= line_t'(1);
      else if (wrap_evt) line_q <= '0;
      else if (cl_step)  line_q <= line_q + line_t'(1);
      if (wrap_evt) fr_q    <= ~fr_q;
      if (cl_step)  fr_seen <= fr_in;
    end
  end
endmodule

// File: rtl/lct_com_dec.sv
module lct_com_dec
  import lct_pkg::*;
(
  input  line_t            line,
  input  logic             duty32,
  input  logic             is_slave,
  output logic [COM_N-1:0] com_sel
);
  logic active;
  assign active = bank_active(duty32, is_slave, line);

  for (genvar g = 0; g < COM_N; g++) begin : g_com
    assign com_sel[g] = active && (line[CW-1:0] == CW'(g));
  end
endmodule

// File: rtl/lct_start_reg.sv
module lct_start_reg
  import lct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  line_t start_d,
  input  line_t line,
  output line_t start_q,
  output line_t row_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    start_q <= '0;
    else if (load) start_q <= start_d;
  end

  assign row_addr = row_of(start_q, line);
endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing
  import lct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cl_step,
  input  logic             duty32,
  input  logic             is_slave,
  input  logic             fr_in,
  input  logic             start_load,
  input  logic [LW-1:0]    start_d,
  output logic             fr_out,
  output logic [LW-1:0]    line_idx,
  output logic [LW-1:0]    row_addr,
  output logic [COM_N-1:0] com_sel
);
  line_t line_q, start_q;
  logic  fr_q, wrap_evt, resync_evt;

  lct_line_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .cl_step(cl_step), .duty32(duty32),
    .is_slave(is_slave), .fr_in(fr_in), .line_q(line_q), .fr_q(fr_q),
    .wrap_evt(wrap_evt), .resync_evt(resync_evt)
  );

  lct_com_dec u_dec (
    .line(line_q), .duty32(duty32), .is_slave(is_slave), .com_sel(com_sel)
  );

  lct_start_reg u_start (
    .clk(clk), .rst_n(rst_n), .load(start_load), .start_d(start_d),
    .line(line_q), .start_q(start_q), .row_addr(row_addr)
  );

  assign line_idx = line_q;
  assign fr_out   = is_slave ? fr_in : fr_q;
endmodule

// File: rtl/lct_checker.sv
module lct_checker
  import lct_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cl_step,
  input logic             duty32,
  input logic             is_slave,
  input logic [LW-1:0]    line_idx,
  input logic [COM_N-1:0] com_sel,
  input logic             fr_q,
  input logic             wrap_evt,
  input logic             resync_evt
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_step |=> $stable(line_idx));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_step && !wrap_evt && !resync_evt) |=> line_idx == $past(line_idx) + LW'(1));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> line_idx == '0);

  p_fr_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> fr_q != $past(fr_q));

  p_fr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(fr_q));

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel));

  p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty32 && (is_slave ? line_idx < LW'(COM_N) : line_idx >= LW'(COM_N)))
      |-> com_sel == '0);

  p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resync_evt |=> line_idx == LW'(1));
endmodule

bind lcd_com_timing lct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cl_step(cl_step), .duty32(duty32),
  .is_slave(is_slave), .line_idx(line_idx), .com_sel(com_sel),
  .fr_q(fr_q), .wrap_evt(wrap_evt), .resync_evt(resync_evt)
);

// File: tb/tb_lcd_com_timing.sv
module tb_lcd_com_timing;
  logic clk = 1'b0, rst_n = 1'b0, cl_step = 1'b0, duty32 = 1'b0;
  logic is_slave = 1'b0, fr_in = 1'b0, start_load = 1'b0;
  logic [4:0] start_d = '0;
  logic fr_out;
  logic [4:0] line_idx, row_addr;
  logic [15:0] com_sel;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, live = 0;
  // behavioural reference state
  int m_line = 0, m_start = 0;
  bit m_fr = 0, m_seen = 0;

  lcd_com_timing dut (.*);

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 0; m_start = 0; m_fr = 0; m_seen = 0;
    end else begin
      if (start_load) m_start = start_d;
      if (cl_step) begin
        if (is_slave && (fr_in != m_seen)) m_line = 1;
        else if (m_line >= (duty32 ? 31 : 15)) begin
          m_line = 0; m_fr = !m_fr;
        end else m_line = m_line + 1;
        m_seen = fr_in;
      end
    end
  end

  function automatic int exp_com();
    bit on;
    if (!duty32) on = 1;
    else if (is_slave) on = (m_line >= 16);
    else on = (m_line < 16);
    return on ? (1 << (m_line % 16)) : 0;
  endfunction

  always @(negedge clk) begin
    if (live) begin
      check("R2", line_idx, m_line);
      check(duty32 ? "R7" : "R6", com_sel, exp_com());
      check("R8", row_addr, (m_start + m_line) % 32);
      check(is_slave ? "R5" : "R4", fr_out, is_slave ? fr_in : m_fr);
    end
  end

  task automatic cyc(bit cl, bit ld = 0, int d = 0);
    cl_step = cl; start_load = ld; start_d = 5'(d);
    @(negedge clk); #1;
    cl_step = 0; start_load = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", line_idx, 0); check("R1", fr_out, 0);
    check("R1", com_sel, 1);  check("R1", row_addr, 0);
    #1 live = 1;
    // R2/R3: 16-line master with gaps
    for (int i = 0; i < 15; i++) begin cyc(1); cyc(0); end
    check("R2", line_idx, 15);
    cyc(1);
    check("R3", line_idx, 0); check("R4", fr_out, 1);
    // R9: start line loads
    cyc(0, 1, 31);
    check("R9", row_addr, 31);
    for (int i = 0; i < 20; i++) cyc(1, (i == 7), 9 + i);
    // R7: 32-line master
    duty32 = 1;
    for (int i = 0; i < 70; i++) cyc(1, (i == 40), 3);
    // R11: drop duty while beyond line 15
    while (line_idx != 20) cyc(1);
    duty32 = 0;
    cyc(1);
    check("R11", line_idx, 0);
    // R5/R10: slave mode, resync in mid-frame
    is_slave = 1; duty32 = 1; fr_in = m_seen;
    for (int i = 0; i < 5; i++) cyc(1);
    fr_in = !fr_in;
    cyc(1);
    check("R10", line_idx, 1);
    for (int i = 0; i < 80; i++) begin
      if (i % 32 == 31) fr_in = !fr_in;
      cyc(1);
    end
    duty32 = 0;
    for (int i = 0; i < 40; i++) cyc(i % 3 != 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule